// File: doc/BRIEF.md
# Dual-Edge Shadow Sampling Error Detector

This block sits on the result bus of a combinational datapath, such as an adder or a multiplier. It catches transient pulses and values that arrive late. Each result bit is captured twice. The functional register takes it on the rising clock edge and sends it on to the consumer at once, with no added latency. A shadow register takes the same bit again on the following falling edge. The high phase of the clock therefore sets the skew between the two samples.

Each bit pair is compared with an XOR. The XORs feed an OR tree, padded to a power-of-two leaf count so that every compared bit passes through the same number of OR stages. The tree result is stored at the next rising edge in an error register, which drives a one-cycle error pulse and a sticky error flag. A per-bit check mask takes chosen bits out of the reduction, and a synchronous clear input drops the sticky flag.

Operands may change every cycle. The scheme assumes that the shortest datapath path is longer than the high phase of the clock, so that the next result cannot reach the shadow sample.

Top module: `shadow_err_detect`

## Requirements
- R1: While rst_n is low, data_out is zero, and out_valid, err_pulse and err_sticky are low.
- R2: At a rising edge where in_valid is high, data_out takes data_in and out_valid goes high, both visible right after that edge. At a rising edge where in_valid is low, data_out holds its value and out_valid goes low.
- R3: After a capture, the shadow register samples data_in at the next falling edge. err_pulse is high for the cycle that starts at the next rising edge if, and only if, some checked bit differs between the two samples.
- R4: A single-bit glitch that is present at the rising-edge sample but gone by the falling edge raises err_pulse.
- R5: A bit that changes after the rising edge but before the falling edge raises err_pulse. This covers a late arrival, and a glitch that is present only at the falling sample.
- R6: Corruption that lands in the functional sample for some bits and in the shadow sample for other bits raises err_pulse.
- R7: Bit k of chk_mask at 1 includes bit k in the check. A mismatch confined to bits whose mask bit is 0 leaves err_pulse low.
- R8: err_sticky rises with err_pulse and stays high until a rising edge with err_clr high. If a new error and err_clr arrive at the same edge, the new error wins and err_sticky stays high.
- R9: With in_valid high on every cycle and stable data in each cycle, data_out follows a new value every cycle and err_pulse stays low.
- R10: Cycles without a capture never raise err_pulse, whatever data_in does.
- R11: Every bit position from 0 to WIDTH-1 reaches the error flag, including the bits on the padded branch of the OR tree when WIDTH is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its high phase sets the shadow skew |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Capture enable for the current datapath result |
| data_in | input | WIDTH | Combinational datapath result |
| chk_mask | input | WIDTH | Per-bit check enable (1 = checked) |
| err_clr | input | 1 | Synchronous clear of the sticky error flag |
| data_out | output | WIDTH | Functional register contents |
| out_valid | output | 1 | data_out was captured at the last rising edge |
| err_pulse | output | 1 | Mismatch found for the previous capture |
| err_sticky | output | 1 | Accumulated error flag |

## Verification
The properties assume that in_valid, chk_mask and err_clr change only away from the rising edge. They also assume that a legal datapath holds data_in steady from a rising edge through the following falling edge, so any difference between the two samples is treated as a fault. The bench drives every control once per cycle, just after the falling edge. It changes data_in in the middle of the high phase only when it means to inject a fault. Fault-free cycles therefore keep the datapath timing that the properties rely on, and faulty cycles place the bad value in exactly one of the two sampling windows.

// File: rtl/shadow_det_pkg.sv
`timescale 1ns/1ps
package shadow_det_pkg;

  // Smallest power of two not below n (at least 1).
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 32; i++) begin
      if (p < n) p = p << 1;
    end
    return p;
  endfunction

  typedef struct packed {
    logic pulse;
    logic sticky;
  } err_state_t;

endpackage

// File: rtl/sd_shadow_bank.sv
`timescale 1ns/1ps
module sd_shadow_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // One falling-edge storage element per checked bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;
    logic bit_d;

    always_comb begin
      bit_d = cap_en ? d_i[b] : bit_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end

    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/sd_mismatch_tree.sv
`timescale 1ns/1ps
module sd_mismatch_tree #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             any_o
);
  import shadow_det_pkg::*;

  localparam int LEAVES = int'(pow2_ceil(WIDTH));
  localparam int DEPTH  = $clog2(LEAVES);

  logic [LEAVES-1:0] leaf;

  // Padding leaves are tied low, so every real bit sees DEPTH OR stages.
  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < WIDTH) begin : g_real
      assign leaf[k] = en_i[k] & (a_i[k] ^ b_i[k]);
    end else begin : g_pad
      assign leaf[k] = 1'b0;
    end
  end

  for (genvar l = 1; l <= DEPTH; l++) begin : lvl
    logic [(LEAVES>>l)-1:0] node;
    for (genvar j = 0; j < (LEAVES>>l); j++) begin : g_pair
      if (l == 1) begin : g_first
        assign node[j] = leaf[2*j] | leaf[2*j+1];
      end else begin : g_upper
        assign node[j] = lvl[l-1].node[2*j] | lvl[l-1].node[2*j+1];
      end
    end
  end

  if (DEPTH == 0) begin : g_single
    assign any_o = leaf[0];
  end else begin : g_root
    assign any_o = lvl[DEPTH].node[0];
  end
endmodule

// File: rtl/sd_err_reg.sv
`timescale 1ns/1ps
module sd_err_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid,
  input  logic cmp_any,
  input  logic clr,
  output logic pulse_o,
  output logic sticky_o
);
  import shadow_det_pkg::*;

  err_state_t st_q;
  err_state_t st_d;

  always_comb begin
    st_d.pulse  = cmp_valid & cmp_any;
    // A fresh error outranks a clear arriving at the same edge.
    st_d.sticky = st_d.pulse | (st_q.sticky & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign pulse_o  = st_q.pulse;
  assign sticky_o = st_q.sticky;
endmodule

// File: rtl/shadow_err_detect.sv
`timescale 1ns/1ps
module shadow_err_detect #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] data_in,
  input  logic [WIDTH-1:0] chk_mask,
  input  logic             err_clr,
  output logic [WIDTH-1:0] data_out,
  output logic             out_valid,
  output logic             err_pulse,
  output logic             err_sticky
);
  logic [WIDTH-1:0] func_q, func_d;
  logic             vld_q, vld_d;
  logic [WIDTH-1:0] shadow_q;
  logic             mis_any;

  // Functional register: the datapath's normal output stage.
  always_comb begin
    func_d = in_valid ? data_in : func_q;
    vld_d  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      func_q <= func_d;
      vld_q  <= vld_d;
    end
  end

  sd_shadow_bank #(.WIDTH(WIDTH)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (vld_q),
    .d_i    (data_in),
    .q_o    (shadow_q)
  );

  sd_mismatch_tree #(.WIDTH(WIDTH)) u_tree (
    .a_i   (func_q),
    .b_i   (shadow_q),
    .en_i  (chk_mask),
    .any_o (mis_any)
  );

  sd_err_reg u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (vld_q),
    .cmp_any   (mis_any),
    .clr       (err_clr),
    .pulse_o   (err_pulse),
    .sticky_o  (err_sticky)
  );

  assign data_out  = func_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/sd_checker.sv
`timescale 1ns/1ps
module sd_checker #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             err_clr,
  input logic [WIDTH-1:0] data_out,
  input logic             out_valid,
  input logic             err_pulse,
  input logic             err_sticky
);
  // R2: no capture means held output and no valid
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(data_out) && !out_valid));

  // R3: a pulse always refers to a capture one cycle earlier
  a_r3_pulse_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(out_valid));

  // R10: a cycle without a capture cannot lead to a pulse
  a_r10_no_pulse_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> !err_pulse);

  // R8: pulse implies flag set
  a_r8_sticky_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  // R8: flag holds without clear
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  // R8: after a clear the flag equals only the fresh error
  a_r8_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_sticky == err_pulse));
endmodule

bind shadow_err_detect sd_checker #(.WIDTH(WIDTH)) u_sd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .err_clr    (err_clr),
  .data_out   (data_out),
  .out_valid  (out_valid),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky)
);

// File: tb/tb_shadow_err_detect.sv
`timescale 1ns/1ps
module tb_shadow_err_detect;
  localparam int W      = 6;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 11;

  typedef struct packed {
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] mask;
    logic         err;
  } vec_t;

  // Rising-edge value, falling-edge value, check mask, expected pulse.
  localparam vec_t VECS [NVEC] = '{
    '{6'h15, 6'h15, 6'h3F, 1'b0},  // R3 match
    '{6'h2A, 6'h2A, 6'h3F, 1'b0},  // R3 match
    '{6'h00, 6'h01, 6'h3F, 1'b1},  // R5 bit0 arrives late
    '{6'h04, 6'h00, 6'h3F, 1'b1},  // R4 bit2 glitch at rise only
    '{6'h20, 6'h00, 6'h3F, 1'b1},  // R11 bit5 (padded branch)
    '{6'h10, 6'h30, 6'h3F, 1'b1},  // R5 bit5 late
    '{6'h3F, 6'h3E, 6'h3E, 1'b0},  // R7 mismatch on masked bit0
    '{6'h3F, 6'h3E, 6'h01, 1'b1},  // R7 only bit0 checked
    '{6'h09, 6'h12, 6'h3F, 1'b1},  // R6 split corruption
    '{6'h21, 6'h21, 6'h00, 1'b0},  // R7 all masked, match
    '{6'h3F, 6'h00, 6'h00, 1'b0}   // R7 all masked, full mismatch
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] data_in;
  logic [W-1:0] chk_mask;
  logic         err_clr;
  logic [W-1:0] data_out;
  logic         out_valid;
  logic         err_pulse;
  logic         err_sticky;

  int n_tests;
  int n_fail;

  shadow_err_detect #(.WIDTH(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .data_in    (data_in),
    .chk_mask   (chk_mask),
    .err_clr    (err_clr),
    .data_out   (data_out),
    .out_valid  (out_valid),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after a falling edge; rise value is captured at the next rising
  // edge, fall value is seen by the following falling edge. Returns just
  // after that rising edge.
  task automatic cap(input logic [W-1:0] rise, input logic [W-1:0] fall,
                     input logic vld, input logic [W-1:0] mask, input logic clr);
    @(negedge clk);
    #1;
    data_in  = rise;
    in_valid = vld;
    chk_mask = mask;
    err_clr  = clr;
    @(posedge clk);
    #1;
    data_in = fall;
  endtask

  function automatic string row_tag(input int i);
    case (i)
      2, 5:          return "R5";
      3:             return "R4";
      4:             return "R11";
      6, 7, 9, 10:   return "R7";
      8:             return "R6";
      default:       return "R3";
    endcase
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    data_in  = '0;
    chk_mask = '1;
    err_clr  = 1'b0;

    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 data_out", 32'(data_out), 0);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 err_pulse", 32'(err_pulse), 0);
    check("R1 err_sticky", 32'(err_sticky), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of vectors
    for (int i = 0; i < NVEC; i++) begin
      cap(VECS[i].rise, VECS[i].fall, 1'b1, VECS[i].mask, 1'b0);
      check("R2 data_out", 32'(data_out), 32'(VECS[i].rise));
      check("R2 out_valid", 32'(out_valid), 1);
      cap(VECS[i].fall, VECS[i].fall, 1'b0, VECS[i].mask, 1'b0);
      check(row_tag(i), 32'(err_pulse), 32'(VECS[i].err));
      check("R8 sticky set", 32'(err_sticky), 32'(VECS[i].err));
      cap(VECS[i].fall, VECS[i].fall, 1'b0, VECS[i].mask, 1'b1);
      check("R8 cleared", 32'(err_sticky), 0);
    end

    // R2 / R10: idle cycles with a toggling bus
    cap(6'h2D, 6'h2D, 1'b1, 6'h3F, 1'b0);
    check("R2 capture", 32'(data_out), 32'h2D);
    cap(6'h12, 6'h33, 1'b0, 6'h3F, 1'b0);
    check("R2 hold", 32'(data_out), 32'h2D);
    check("R2 valid low", 32'(out_valid), 0);
    check("R10 pulse", 32'(err_pulse), 0);
    cap(6'h0F, 6'h30, 1'b0, 6'h3F, 1'b0);
    check("R2 hold 2", 32'(data_out), 32'h2D);
    check("R10 pulse idle", 32'(err_pulse), 0);
    check("R10 sticky idle", 32'(err_sticky), 0);

    // R9: back-to-back captures at full rate
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] v;
      v = W'((k * 13 + 5) % 64);
      cap(v, v, 1'b1, 6'h3F, 1'b0);
      check("R9 data_out", 32'(data_out), 32'(v));
      check("R9 out_valid", 32'(out_valid), 1);
      if (k > 0) check("R9 no error", 32'(err_pulse), 0);
    end
    cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b0);
    check("R9 last no error", 32'(err_pulse), 0);
    check("R9 sticky", 32'(err_sticky), 0);

    // R8: sticky holds over idle cycles
    cap(6'h08, 6'h00, 1'b1, 6'h3F, 1'b0);
    cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b0);
    check("R8 pulse", 32'(err_pulse), 1);
    check("R8 sticky", 32'(err_sticky), 1);
    for (int k = 0; k < 3; k++) begin
      cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b0);
      check("R8 pulse gone", 32'(err_pulse), 0);
      check("R8 sticky holds", 32'(err_sticky), 1);
    end
    cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b1);
    check("R8 clear", 32'(err_sticky), 0);

    // R8: new error and clear at the same edge; error wins
    cap(6'h00, 6'h02, 1'b1, 6'h3F, 1'b0);
    cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b1);
    check("R8 set wins pulse", 32'(err_pulse), 1);
    check("R8 set wins sticky", 32'(err_sticky), 1);
    cap(6'h00, 6'h00, 1'b0, 6'h3F, 1'b1);
    check("R8 later clear", 32'(err_sticky), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule